// File: doc/BRIEF.md
# Fixed-Point Requantizer

This block takes a signed two's complement fixed-point sample in a wide format and re-expresses it in a narrower output format. Each format is described by a count of integer bits (the sign bit included) and a count of fractional bits, both set by parameters. A parameter can also force the output format to be identical to the input format.

Two small mode inputs are sampled with every valid input sample, so the behaviour can change from one sample to the next. The quantization mode decides how surplus fractional bits are removed: floor, round to nearest, or round toward zero. The overflow mode decides what happens when the quantized value does not fit the output integer range: wrap-around or clamping. Round toward zero is intended for the feedback path of recursive filters, because it never increases the magnitude of a value.

A registered result appears one clock after the input, with a valid bit and an overflow flag.

Top module: `fxp_requant`

## Requirements
- R1: A synchronous active-high `rst` clears `out_data`, `out_vld` and `out_ovf` to zero on the next rising clock edge.
- R2: `out_vld` equals the `in_vld` of the previous clock cycle. Each result appears exactly one cycle after its input. `out_data` holds its value while `in_vld` is low.
- R3: With `qmode` = 0 (floor), the surplus fractional bits are discarded, which rounds toward minus infinity. For example, Q8.8 value 0xFED8 (-18.5 output LSBs) gives Q4.4 0xED.
- R4: With `qmode` = 1 (round), half an output LSB is added before the surplus bits are discarded, so an exact half rounds toward plus infinity. The sum is one bit wider than the input, so Q8.8 0x7FFF rounds to +2048 output LSBs, and that value is then handled by the overflow mode.
- R5: With `qmode` = 2 (round toward zero), a non-negative input is truncated. A negative input with any non-zero discarded bit gets one output LSB added after truncation. The output magnitude never exceeds the input magnitude.
- R6: The reserved code `qmode` = 3 behaves exactly as floor.
- R7: With `omode` = 0 (wrap), an out-of-range value keeps only its low output-width bits.
- R8: With `omode` = 1 (saturate), an out-of-range value becomes the most positive code (0 then all ones) or the most negative code (1 then all zeros), according to its sign.
- R9: `out_ovf` is high in the same cycle as a valid output whose quantized value did not fit the output range, in both overflow modes. It is low for all other outputs and whenever `out_vld` is low.
- R10: When the output has more fractional bits than the input, the input is sign-extended and shifted left with zero fill, and no rounding occurs. For example, Q4.4 0x9C gives Q6.6 0xE70.
- R11: With `SAME_FMT` = 1, the output format equals the input format, `out_data` equals `in_data`, and `out_ovf` stays low, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample valid |
| in_data | input | IN_INT+IN_FRAC | Input sample, signed fixed point |
| qmode | input | 2 | Quantization: 0 floor, 1 round, 2 toward zero, 3 floor |
| omode | input | 1 | Overflow handling: 0 wrap, 1 saturate |
| out_vld | output | 1 | Output sample valid |
| out_data | output | OUT_INT+OUT_FRAC (or input width when SAME_FMT) | Output sample, signed fixed point |
| out_ovf | output | 1 | Output sample did not fit the output range |

## Verification
The hardest case to reach is the one where the rounding addition itself carries past the top of the input word. Only the largest positive inputs in round mode can do this, and they expose whether the sum was widened. The stimulus table drives 0x7FFF and values just below the positive output limit in round mode under both overflow modes, and expects a wrapped 0x00 or a clamped 0x7F with the flag set. A second difficult region is small negative inputs, where floor, round and round-toward-zero all give different answers. These are covered by directed vectors and by a strided sweep of the input range that is compared against a bench-side integer model.

// File: rtl/fxp_rq_pkg.sv
package fxp_rq_pkg;

    typedef enum logic [1:0] {
        QM_FLOOR = 2'd0,
        QM_ROUND = 2'd1,
        QM_ZERO  = 2'd2,
        QM_RSVD  = 2'd3
    } qmode_t;

    typedef enum logic {
        OM_WRAP = 1'b0,
        OM_SAT  = 1'b1
    } omode_t;

endpackage

// File: rtl/fxp_rq_quant.sv
module fxp_rq_quant #(
    parameter int IN_INT   = 8,
    parameter int IN_FRAC  = 8,
    parameter int OUT_FRAC = 4,
    localparam int IW = IN_INT + IN_FRAC,
    localparam int MW = IN_INT + OUT_FRAC + 1
) (
    input  logic [IW-1:0]        x,
    input  logic [1:0]           mode,
    output logic signed [MW-1:0] y
);
    import fxp_rq_pkg::*;

    generate
        if (OUT_FRAC >= IN_FRAC) begin : g_shift
            localparam int SH = OUT_FRAC - IN_FRAC;
            logic signed [MW-1:0] ext;
            logic [1:0] unused_mode;
            assign unused_mode = mode;
            assign ext = MW'($signed(x));
            assign y   = ext <<< SH;
        end else begin : g_drop
            localparam int D = IN_FRAC - OUT_FRAC;
            logic signed [IW:0] xe;
            logic signed [IW:0] half;
            logic signed [IW:0] sum;
            logic signed [IW:0] tr;
            logic signed [IW:0] rd;
            logic signed [IW:0] fx;
            logic               frac_nz;
            logic               bump;

            assign xe      = (IW+1)'($signed(x));
            assign half    = (IW+1)'(1) <<< (D-1);
            assign sum     = xe + half;
            assign tr      = xe >>> D;
            assign rd      = sum >>> D;
            assign frac_nz = |x[D-1:0];
            assign bump    = x[IW-1] & frac_nz;
            assign fx      = tr + $signed({{IW{1'b0}}, bump});

            always_comb begin
                unique case (qmode_t'(mode))
                    QM_ROUND: y = MW'(rd);
                    QM_ZERO:  y = MW'(fx);
                    default:  y = MW'(tr);
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/fxp_rq_range.sv
module fxp_rq_range #(
    parameter int MW = 13,
    parameter int OW = 8
) (
    input  logic signed [MW-1:0] v,
    input  logic                 sat,
    output logic [OW-1:0]        q,
    output logic                 ovf
);
    localparam logic [OW-1:0] MAXC = {1'b0, {(OW-1){1'b1}}};
    localparam logic [OW-1:0] MINC = {1'b1, {(OW-1){1'b0}}};

    generate
        if (MW > OW) begin : g_chk
            logic [MW-OW:0] hi;
            logic           fits;
            assign hi   = v[MW-1:OW-1];
            assign fits = (&hi) | ~(|hi);
            assign ovf  = ~fits;
            always_comb begin
                if (fits)
                    q = v[OW-1:0];
                else if (sat)
                    q = v[MW-1] ? MINC : MAXC;
                else
                    q = v[OW-1:0];
            end
        end else begin : g_fit
            logic unused_sat;
            assign unused_sat = sat;
            assign q   = OW'(v);
            assign ovf = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/fxp_requant.sv
module fxp_requant #(
    parameter int IN_INT   = 8,
    parameter int IN_FRAC  = 8,
    parameter int OUT_INT  = 4,
    parameter int OUT_FRAC = 4,
    parameter bit SAME_FMT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_vld,
    input  logic [IN_INT+IN_FRAC-1:0] in_data,
    input  logic [1:0]           qmode,
    input  logic                 omode,
    output logic                 out_vld,
    output logic [(SAME_FMT ? IN_INT+IN_FRAC : OUT_INT+OUT_FRAC)-1:0] out_data,
    output logic                 out_ovf
);
    localparam int EF = SAME_FMT ? IN_FRAC : OUT_FRAC;
    localparam int EI = SAME_FMT ? IN_INT : OUT_INT;
    localparam int IW = IN_INT + IN_FRAC;
    localparam int OW = EI + EF;
    localparam int MW = IN_INT + EF + 1;

    logic signed [MW-1:0] mid;
    logic [OW-1:0]        q_nxt;
    logic                 ovf_nxt;

    fxp_rq_quant #(
        .IN_INT  (IN_INT),
        .IN_FRAC (IN_FRAC),
        .OUT_FRAC(EF)
    ) u_quant (
        .x   (in_data),
        .mode(qmode),
        .y   (mid)
    );

    fxp_rq_range #(
        .MW(MW),
        .OW(OW)
    ) u_range (
        .v  (mid),
        .sat(omode),
        .q  (q_nxt),
        .ovf(ovf_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_ovf  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= in_vld;
            out_ovf <= in_vld & ovf_nxt;
            if (in_vld)
                out_data <= q_nxt;
        end
    end

endmodule

// File: rtl/fxp_rq_chk.sv
module fxp_rq_chk #(
    parameter int OW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          in_vld,
    input logic          in_msb,
    input logic [1:0]    qmode,
    input logic          omode,
    input logic          out_vld,
    input logic [OW-1:0] out_data,
    input logic          out_ovf
);
    localparam logic [OW-1:0] MAXC = {1'b0, {(OW-1){1'b1}}};
    localparam logic [OW-1:0] MINC = {1'b1, {(OW-1){1'b0}}};

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_vld && !out_ovf && out_data == '0));

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && $stable(out_data)));

    // R9
    ovf_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> out_vld);

    // R8
    sat_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && omode) |=> (!out_ovf || out_data == MAXC || out_data == MINC));

    // R5
    zero_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && omode && qmode == 2'd2 && !in_msb) |=> !out_data[OW-1]);

    // R3
    floor_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && omode && qmode == 2'd0 && in_msb) |=> out_data[OW-1]);

endmodule

bind fxp_requant fxp_rq_chk #(.OW(OW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_vld),
    .in_msb  (in_data[IW-1]),
    .qmode   (qmode),
    .omode   (omode),
    .out_vld (out_vld),
    .out_data(out_data),
    .out_ovf (out_ovf)
);

// File: tb/fxp_requant_tb.sv
module fxp_requant_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 22;

    // vector: [27:12] input, [11:10] qmode, [9] omode, [8] ovf, [7:0] out
    localparam logic [27:0] VEC [NV] = '{
        {16'h0128, 2'd0, 1'b1, 1'b0, 8'h12},  // R3 floor positive half
        {16'h0128, 2'd1, 1'b1, 1'b0, 8'h13},  // R4 tie up
        {16'h0128, 2'd2, 1'b1, 1'b0, 8'h12},  // R5
        {16'hFED8, 2'd0, 1'b1, 1'b0, 8'hED},  // R3
        {16'hFED8, 2'd1, 1'b1, 1'b0, 8'hEE},  // R4 tie toward +inf
        {16'hFED8, 2'd2, 1'b1, 1'b0, 8'hEE},  // R5
        {16'h0127, 2'd1, 1'b0, 1'b0, 8'h12},  // R4 below half
        {16'hFED9, 2'd0, 1'b0, 1'b0, 8'hED},  // R3
        {16'hFED9, 2'd2, 1'b0, 1'b0, 8'hEE},  // R5
        {16'hFFFF, 2'd0, 1'b0, 1'b0, 8'hFF},  // R3 tiny negative
        {16'hFFFF, 2'd2, 1'b0, 1'b0, 8'h00},  // R5 tiny negative
        {16'hFFFF, 2'd3, 1'b0, 1'b0, 8'hFF},  // R6 reserved = floor
        {16'hFED9, 2'd3, 1'b1, 1'b0, 8'hED},  // R6
        {16'h0900, 2'd0, 1'b1, 1'b1, 8'h7F},  // R8 positive clamp
        {16'h0900, 2'd0, 1'b0, 1'b1, 8'h90},  // R7 wrap
        {16'hF700, 2'd0, 1'b1, 1'b1, 8'h80},  // R8 negative clamp
        {16'hF700, 2'd0, 1'b0, 1'b1, 8'h70},  // R7
        {16'h07F8, 2'd0, 1'b1, 1'b0, 8'h7F},  // R9 fits
        {16'h07F8, 2'd1, 1'b1, 1'b1, 8'h7F},  // R4 round causes overflow
        {16'h7FFF, 2'd1, 1'b0, 1'b1, 8'h00},  // R4 widened sum
        {16'hF800, 2'd2, 1'b0, 1'b0, 8'h80},  // R9 min fits
        {16'h8000, 2'd0, 1'b0, 1'b1, 8'h00}   // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [15:0] din = '0;
    logic [7:0]  din_w = '0;
    logic [1:0]  qmode = '0;
    logic        omode = 1'b0;
    logic        d_vld, s_vld, w_vld;
    logic [7:0]  d_out;
    logic [15:0] s_out;
    logic [11:0] w_out;
    logic        d_ovf, s_ovf, w_ovf;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxp_requant u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(din),
        .qmode(qmode), .omode(omode),
        .out_vld(d_vld), .out_data(d_out), .out_ovf(d_ovf)
    );

    fxp_requant #(.SAME_FMT(1'b1)) u_same (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(din),
        .qmode(qmode), .omode(omode),
        .out_vld(s_vld), .out_data(s_out), .out_ovf(s_ovf)
    );

    fxp_requant #(.IN_INT(4), .IN_FRAC(4), .OUT_INT(6), .OUT_FRAC(6)) u_wide (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(din_w),
        .qmode(qmode), .omode(omode),
        .out_vld(w_vld), .out_data(w_out), .out_ovf(w_ovf)
    );

    function automatic logic [8:0] model(input int x, input int qm, input bit om);
        int  y;
        bit  ov;
        case (qm)
            1:       y = (x + 8) >>> 4;
            2:       y = (x < 0) ? -((-x) >>> 4) : (x >>> 4);
            default: y = x >>> 4;
        endcase
        ov = (y > 127) || (y < -128);
        if (ov && om) y = (y > 0) ? 127 : -128;
        return {ov, y[7:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] d, input logic [1:0] qm, input logic om);
        @(negedge clk);
        in_vld = 1'b1;
        din    = d;
        qmode  = qm;
        omode  = om;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 vld", {31'd0, d_vld}, 32'd0);
        check("R1 data", {24'd0, d_out}, 32'd0);
        check("R1 ovf", {31'd0, d_ovf}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][27:12], VEC[i][11:10], VEC[i][9]);
            check("R2 vld", {31'd0, d_vld}, 32'd1);
            check("R3-7 data", {24'd0, d_out}, {24'd0, VEC[i][7:0]});
            check("R9 ovf", {31'd0, d_ovf}, {31'd0, VEC[i][8]});
        end

        // R2: idle cycle holds data, clears valid and flag
        apply(16'h0900, 2'd0, 1'b0);
        in_vld = 1'b0;
        din    = 16'h0010;
        @(negedge clk);
        check("R2 idle vld", {31'd0, d_vld}, 32'd0);
        check("R2 hold data", {24'd0, d_out}, 32'h90);
        check("R9 idle ovf", {31'd0, d_ovf}, 32'd0);

        // R11 same format passthrough
        apply(16'h8001, 2'd1, 1'b1);
        check("R11 data", {16'd0, s_out}, 32'h8001);
        check("R11 ovf", {31'd0, s_ovf}, 32'd0);
        apply(16'h7FFF, 2'd2, 1'b0);
        check("R11 data", {16'd0, s_out}, 32'h7FFF);

        // R10 left shift with zero fill
        din_w = 8'h9C;
        apply(16'h0000, 2'd1, 1'b0);
        check("R10 neg", {20'd0, w_out}, 32'hE70);
        check("R10 ovf", {31'd0, w_ovf}, 32'd0);
        din_w = 8'h5A;
        apply(16'h0000, 2'd2, 1'b1);
        check("R10 pos", {20'd0, w_out}, 32'h168);

        // sweep against integer model: R3 R4 R5 R7 R8 R9
        for (int x = -32768; x < 32768; x += 37) begin
            for (int m = 0; m < 8; m++) begin
                logic [8:0] e;
                e = model(x, m >> 1, m[0]);
                apply(16'(x), 2'(m >> 1), m[0]);
                check("R3-R9 sweep data", {24'd0, d_out}, {24'd0, e[7:0]});
                check("R9 sweep ovf", {31'd0, d_ovf}, {31'd0, e[8]});
            end
        end

        // R1 reset mid-stream
        apply(16'h0900, 2'd0, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 rerst vld", {31'd0, d_vld}, 32'd0);
        check("R1 rerst data", {24'd0, d_out}, 32'd0);
        check("R1 rerst ovf", {31'd0, d_ovf}, 32'd0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule